// File: doc/BRIEF.md
# Memory Region Security Access Checker

This block sits in front of a memory and decides, for every transaction, whether the access may go through. A transaction carries an address, a read/write flag and a secure/non-secure flag. The block compares the address against a set of programmable regions. Each region has a size-aligned base, a power-of-two size code, an enable bit and a four-bit permission field. The permission field of the single winning region decides the transaction.

Region 0 is a fixed background region that covers the whole address space, and only its permissions can be changed. A small register window reports the region count and holds a security-inversion control. It also holds each region's setup words. An allowed transaction is forwarded one cycle later. A denied one raises a one-cycle deny flag in that same cycle and is not forwarded. A lock input freezes the configuration until reset.

Top module: `secchk_top`

## Requirements
- R1: The register at offset 0x000 is read-only and returns the number of regions minus one in bits 3:0, with zeros above.
- R2: Region n owns offsets 0x100+0x10*n (base word: only bits 31:15 stored, lower bits read 0), +0x4 (high base: writes ignored, reads 0) and +0x8 (attributes: bit 0 enable, bits 6:1 size code, bits 31:28 permission, other bits read 0).
- R3: Region 0 matches every address. Writes to its base word and to its enable and size bits are ignored. Its attribute word reads enable 1 and size code 63, and its permission resets to 4'b1100.
- R4: An enabled region n>0 with size code c covers a 2^(c+1)-byte block: the address matches when the address bits above bit c equal the base bits there. A code below 14 acts as 14, and a code of 31 or more covers all 32-bit addresses.
- R5: Permission bit 3 grants secure read, bit 2 secure write, bit 1 non-secure read and bit 0 non-secure write.
- R6: The inversion control is bit 0 at offset 0x004 and resets to 0. While it is 0, a non-secure read grant also grants secure read, and a non-secure write grant also grants secure write. While it is 1, the permission is used exactly as written.
- R7: When several regions match, the enabled matching region with the highest index decides.
- R8: A region whose enable bit is 0 takes no part in matching, and its base, size and permission read back unchanged.
- R9: A transaction presented with txn_valid yields exactly one of two results in the next cycle: fwd_valid with the same address, write and secure flags, or deny_pulse. With no transaction, both outputs stay low.
- R10: A configuration write is ignored in any cycle where lock_in is high and in every cycle after lock_in has been high. Only reset clears this.
- R11: After reset, regions 1 and up read all zero (disabled), and fwd_valid and deny_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_in | input | 1 | Configuration lock request (latched until reset) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset (word aligned) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_addr | input | 32 | Transaction address |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_secure | input | 1 | 1 = secure, 0 = non-secure |
| fwd_valid | output | 1 | Allowed transaction forwarded |
| fwd_addr | output | 32 | Forwarded address |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_secure | output | 1 | Forwarded secure flag |
| deny_pulse | output | 1 | One-cycle flag for a denied transaction |

## Verification
The hardest case to reach from the ports is an address claimed by several enabled regions with conflicting permissions. A sub-minimum size code must also take effect in the same place. The stimulus builds this by stacking a small denying region over a whole-space allowing region, which in turn sits over a mid-size denying one. It then probes addresses just inside and just outside each edge, and toggles the enable bit of the top region. A behavioural model then follows a long run of mixed transactions and configuration writes. It also checks that a one-cycle lock pulse freezes the configuration for good.

// File: rtl/secchk_pkg.sv
package secchk_pkg;

  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned CFG_AW   = 12;
  localparam int unsigned PERM_W   = 4;
  localparam int unsigned CODE_W   = 6;
  localparam int unsigned MIN_CODE = 14;
  localparam int unsigned GRAN_LSB = 15;
  localparam int unsigned BG_CODE  = 63;

  typedef struct packed {
    logic                     en;
    logic [CODE_W-1:0]        code;
    logic [PERM_W-1:0]        perm;
    logic [ADDR_W-1:GRAN_LSB] base;
  } region_cfg_t;

  // Does a region with this base and size code contain the address?
  function automatic logic region_covers(logic [ADDR_W-1:0] a,
                                         logic [ADDR_W-1:GRAN_LSB] b,
                                         logic [CODE_W-1:0] code);
    int unsigned c;
    logic [ADDR_W-1:0] mask;
    c = (int'(code) < int'(MIN_CODE)) ? MIN_CODE : int'(code);
    if (c + 1 >= ADDR_W) return 1'b1;
    mask = {ADDR_W{1'b1}} << (c + 1);
    return ((a & mask) == ({b, {GRAN_LSB{1'b0}}} & mask));
  endfunction

  // Without inversion, non-secure grants imply the matching secure grants.
  function automatic logic [PERM_W-1:0] fold_perm(logic [PERM_W-1:0] p, logic inv);
    return inv ? p : (p | {p[1:0], 2'b00});
  endfunction

  // Bit 3 SR, bit 2 SW, bit 1 NR, bit 0 NW.
  function automatic logic perm_grant(logic [PERM_W-1:0] p, logic sec, logic wr);
    return p[{sec, ~wr}];
  endfunction

  function automatic logic [31:0] pack_attr(region_cfg_t r);
    return {r.perm, 21'b0, r.code, r.en};
  endfunction

endpackage

// File: rtl/secchk_regs.sv
module secchk_regs
  import secchk_pkg::*;
#(
  parameter int unsigned N_REGIONS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_in,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output region_cfg_t       region_q [N_REGIONS],
  output logic              inv_en,
  output logic              lock_q,
  output logic              wr_accept
);

  localparam logic [CFG_AW-1:0] OFS_INFO = CFG_AW'('h000);
  localparam logic [CFG_AW-1:0] OFS_INV  = CFG_AW'('h004);
  localparam logic [1:0] W_BASE = 2'd0;
  localparam logic [1:0] W_ATTR = 2'd2;

  logic       grp_sel;
  logic [1:0] word;
  logic [3:0] rgn_sel;
  logic       unused_bits;

  assign grp_sel     = (cfg_addr[CFG_AW-1:8] == 4'h1);
  assign word        = cfg_addr[3:2];
  assign rgn_sel     = cfg_addr[7:4];
  assign wr_accept   = cfg_we & ~lock_q & ~lock_in;
  assign unused_bits = ^{cfg_wdata[14:7], cfg_addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_q | lock_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                inv_en <= 1'b0;
    else if (wr_accept && cfg_addr == OFS_INV) inv_en <= cfg_wdata[0];
  end

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_rgn
    logic sel;
    assign sel = wr_accept && grp_sel && (rgn_sel == 4'(g));
    if (g == 0) begin : g_bg
      logic [PERM_W-1:0] bg_perm;
      always_ff @(posedge clk) begin
        if (!rst_n)                    bg_perm <= 4'b1100;
        else if (sel && word == W_ATTR) bg_perm <= cfg_wdata[31:28];
      end
      assign region_q[g] = '{en: 1'b1, code: CODE_W'(BG_CODE), perm: bg_perm, base: '0};
    end else begin : g_prog
      region_cfg_t r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          r <= '0;
        end else if (sel) begin
          if (word == W_BASE) r.base <= cfg_wdata[ADDR_W-1:GRAN_LSB];
          if (word == W_ATTR) begin
            r.perm <= cfg_wdata[31:28];
            r.code <= cfg_wdata[6:1];
            r.en   <= cfg_wdata[0];
          end
        end
      end
      assign region_q[g] = r;
    end
  end

  always_comb begin
    region_cfg_t rsel;
    logic        rhit;
    rsel      = '0;
    rhit      = 1'b0;
    cfg_rdata = '0;
    for (int i = 0; i < N_REGIONS; i++) begin
      if (rgn_sel == 4'(i)) begin
        rsel = region_q[i];
        rhit = 1'b1;
      end
    end
    if (cfg_addr == OFS_INFO) begin
      cfg_rdata[3:0] = 4'(N_REGIONS - 1);
    end else if (cfg_addr == OFS_INV) begin
      cfg_rdata[0] = inv_en;
    end else if (grp_sel && rhit) begin
      if (word == W_BASE)      cfg_rdata = {rsel.base, {GRAN_LSB{1'b0}}};
      else if (word == W_ATTR) cfg_rdata = pack_attr(rsel);
    end
  end

endmodule

// File: rtl/secchk_match.sv
module secchk_match
  import secchk_pkg::*;
#(
  parameter int unsigned N_REGIONS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  region_cfg_t          region_q [N_REGIONS],
  output logic [N_REGIONS-1:0] hit_vec,
  output logic [IDX_W-1:0]     win_idx,
  output logic [PERM_W-1:0]    win_perm
);

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_hit
    assign hit_vec[g] = region_q[g].en &&
                        region_covers(addr, region_q[g].base, region_q[g].code);
  end

  // Highest matching index wins; region 0 is the fallback.
  always_comb begin
    win_idx  = '0;
    win_perm = region_q[0].perm;
    for (int i = 1; i < N_REGIONS; i++) begin
      if (hit_vec[i]) begin
        win_idx  = IDX_W'(i);
        win_perm = region_q[i].perm;
      end
    end
  end

endmodule

// File: rtl/secchk_top.sv
module secchk_top
  import secchk_pkg::*;
#(
  parameter int unsigned N_REGIONS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_in,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              txn_valid,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_write,
  input  logic              txn_secure,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_write,
  output logic              fwd_secure,
  output logic              deny_pulse
);

  localparam int unsigned IDX_W = $clog2(N_REGIONS);

  region_cfg_t          region_q [N_REGIONS];
  logic                 inv_en;
  logic                 lock_q;
  logic                 wr_accept;
  logic [N_REGIONS-1:0] hit_vec;
  logic [IDX_W-1:0]     win_idx;
  logic [PERM_W-1:0]    win_perm;
  logic [PERM_W-1:0]    perm_eff;
  logic                 allow_now;

  secchk_regs #(.N_REGIONS(N_REGIONS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_in  (lock_in),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .region_q (region_q),
    .inv_en   (inv_en),
    .lock_q   (lock_q),
    .wr_accept(wr_accept)
  );

  secchk_match #(.N_REGIONS(N_REGIONS), .IDX_W(IDX_W)) u_match (
    .addr    (txn_addr),
    .region_q(region_q),
    .hit_vec (hit_vec),
    .win_idx (win_idx),
    .win_perm(win_perm)
  );

  assign perm_eff  = fold_perm(win_perm, inv_en);
  assign allow_now = perm_grant(perm_eff, txn_secure, txn_write);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid  <= 1'b0;
      deny_pulse <= 1'b0;
      fwd_addr   <= '0;
      fwd_write  <= 1'b0;
      fwd_secure <= 1'b0;
    end else begin
      fwd_valid  <= txn_valid & allow_now;
      deny_pulse <= txn_valid & ~allow_now;
      if (txn_valid && allow_now) begin
        fwd_addr   <= txn_addr;
        fwd_write  <= txn_write;
        fwd_secure <= txn_secure;
      end
    end
  end

endmodule

// File: rtl/secchk_chk.sv
module secchk_chk
  import secchk_pkg::*;
#(
  parameter int unsigned N_REGIONS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lock_in,
  input logic [CFG_AW-1:0]    cfg_addr,
  input logic [31:0]          cfg_rdata,
  input logic                 txn_valid,
  input logic [ADDR_W-1:0]    txn_addr,
  input logic                 fwd_valid,
  input logic [ADDR_W-1:0]    fwd_addr,
  input logic                 deny_pulse,
  input logic                 allow_now,
  input logic                 lock_q,
  input logic                 wr_accept,
  input logic [N_REGIONS-1:0] hit_vec,
  input logic [IDX_W-1:0]     win_idx
);

  // R1
  info_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == '0) |-> (cfg_rdata == 32'(N_REGIONS - 1)));

  // R7
  winner_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec[win_idx]);

  // R9
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, deny_pulse}));

  // R9
  answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> (fwd_valid || deny_pulse));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> (!fwd_valid && !deny_pulse));

  // R9
  fwd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && allow_now) |=> (fwd_valid && fwd_addr == $past(txn_addr)));

  // R10
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_in |=> lock_q);

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R10
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q || lock_in) |-> !wr_accept);

endmodule

bind secchk_top secchk_chk #(.N_REGIONS(N_REGIONS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lock_in   (lock_in),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .txn_valid (txn_valid),
  .txn_addr  (txn_addr),
  .fwd_valid (fwd_valid),
  .fwd_addr  (fwd_addr),
  .deny_pulse(deny_pulse),
  .allow_now (allow_now),
  .lock_q    (lock_q),
  .wr_accept (wr_accept),
  .hit_vec   (hit_vec),
  .win_idx   (win_idx)
);

// File: tb/secchk_top_tb.sv
module secchk_top_tb;
  localparam int N = 8;

  logic        clk = 1'b0, rst_n = 1'b0, lock_in = 1'b0, cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        txn_valid = 1'b0, txn_write = 1'b0, txn_secure = 1'b0;
  logic [31:0] txn_addr = '0;
  logic        fwd_valid, fwd_write, fwd_secure, deny_pulse;
  logic [31:0] fwd_addr;

  int    checks = 0, fails = 0;
  string cur_req = "R11";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  secchk_top #(.N_REGIONS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_write(txn_write),
    .txn_secure(txn_secure), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .fwd_write(fwd_write), .fwd_secure(fwd_secure), .deny_pulse(deny_pulse)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_base [N];
  int          m_code [N];
  bit          m_en   [N];
  logic [3:0]  m_perm [N];
  bit          m_inv, m_lock;
  bit          e_valid, e_deny, e_wr, e_sec;
  logic [31:0] e_addr;

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin
      m_base[i] = 0; m_code[i] = 0; m_en[i] = 0; m_perm[i] = 0;
    end
    m_perm[0] = 4'b1100;
    m_inv = 0; m_lock = 0;
  endfunction

  function automatic bit model_allow(logic [31:0] a, bit wr, bit sec);
    int win = 0;
    int c;
    longint unsigned span, ua, ub;
    logic [3:0] p;
    for (int i = 1; i < N; i++) begin
      if (m_en[i]) begin
        c = (m_code[i] < 14) ? 14 : m_code[i];
        if (c >= 31) win = i;
        else begin
          span = 64'd1 << (c + 1);
          ua = a; ub = m_base[i];
          if (ua / span == ub / span) win = i;
        end
      end
    end
    p = m_perm[win];
    if (!m_inv) begin
      if (p[1]) p[3] = 1'b1;
      if (p[0]) p[2] = 1'b1;
    end
    if (sec) return wr ? p[2] : p[3];
    return wr ? p[0] : p[1];
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    int idx;
    if (a == 12'h000) return 32'(N - 1);
    if (a == 12'h004) return {31'b0, m_inv};
    if (a[11:8] != 4'h1) return 0;
    idx = int'(a[7:4]);
    if (idx >= N) return 0;
    if (a[3:2] == 2'd0) return (idx == 0) ? 32'h0 : m_base[idx];
    if (a[3:2] == 2'd2) begin
      if (idx == 0) return {m_perm[0], 21'b0, 6'd63, 1'b1};
      return {m_perm[idx], 21'b0, 6'(m_code[idx]), m_en[idx]};
    end
    return 0;
  endfunction

  function automatic void model_write(logic [11:0] a, logic [31:0] d);
    int idx;
    if (a == 12'h004) m_inv = d[0];
    else if (a[11:8] == 4'h1) begin
      idx = int'(a[7:4]);
      if (idx < N) begin
        if (a[3:2] == 2'd0 && idx != 0) m_base[idx] = d & 32'hFFFF_8000;
        if (a[3:2] == 2'd2) begin
          m_perm[idx] = d[31:28];
          if (idx != 0) begin
            m_en[idx] = d[0];
            m_code[idx] = int'(d[6:1]);
          end
        end
      end
    end
  endfunction

  always @(posedge clk) begin
    bit ok;
    if (!rst_n) begin
      model_reset();
      e_valid <= 0; e_deny <= 0; e_addr <= 0; e_wr <= 0; e_sec <= 0;
    end else begin
      ok = model_allow(txn_addr, txn_write, txn_secure);
      e_valid <= txn_valid && ok;
      e_deny  <= txn_valid && !ok;
      e_addr  <= txn_addr; e_wr <= txn_write; e_sec <= txn_secure;
      if (cfg_we && !m_lock && !lock_in) model_write(cfg_addr, cfg_wdata);
      if (lock_in) m_lock = 1;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R9).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "fwd_valid vs model", {31'b0, fwd_valid}, {31'b0, e_valid});
      chk(cur_req, "deny_pulse vs model", {31'b0, deny_pulse}, {31'b0, e_deny});
      if (e_valid) begin
        chk(cur_req, "fwd_addr vs model", fwd_addr, e_addr);
        chk(cur_req, "fwd flags vs model", {30'b0, fwd_write, fwd_secure}, {30'b0, e_wr, e_sec});
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(req, $sformatf("read 0x%03h", a), cfg_rdata, exp);
  endtask

  task automatic txn(logic [31:0] a, bit w, bit s, bit exp_allow, string req);
    cur_req = req;
    @(negedge clk);
    txn_valid = 1; txn_addr = a; txn_write = w; txn_secure = s;
    @(negedge clk);
    txn_valid = 0;
    chk(req, $sformatf("deny for %h w%0d s%0d", a, w, s), {31'b0, deny_pulse}, {31'b0, !exp_allow});
    chk(req, "forward", {31'b0, fwd_valid}, {31'b0, exp_allow});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cfg_we = 0; txn_valid = 0; lock_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 / R1 / R3 / R6 reset state
    @(negedge clk);
    chk("R11", "idle outputs", {30'b0, fwd_valid, deny_pulse}, 32'h0);
    rd_chk(12'h000, 32'h7, "R1");
    rd_chk(12'h108, 32'hC000_007F, "R3");
    rd_chk(12'h118, 32'h0, "R11");
    rd_chk(12'h004, 32'h0, "R6");

    // R3 / R5 background region
    txn(32'h8000_0000, 0, 1, 1, "R3");
    txn(32'h8000_0000, 1, 0, 0, "R5");
    txn(32'h8000_0000, 1, 1, 1, "R5");
    wr(12'h100, 32'h1234_8000);
    rd_chk(12'h100, 32'h0, "R3");
    wr(12'h108, 32'h3000_0000);
    rd_chk(12'h108, 32'h3000_007F, "R3");

    // R6 inversion
    txn(32'h0000_0100, 0, 1, 1, "R6");
    txn(32'h0000_0100, 1, 0, 1, "R5");
    wr(12'h004, 32'h1);
    rd_chk(12'h004, 32'h1, "R6");
    txn(32'h0000_0100, 0, 1, 0, "R6");
    txn(32'h0000_0100, 0, 0, 1, "R6");

    // R2 / R4 region 1
    wr(12'h110, 32'h0001_7FFF);
    rd_chk(12'h110, 32'h0001_0000, "R2");
    wr(12'h114, 32'hFFFF_FFFF);
    rd_chk(12'h114, 32'h0, "R2");
    wr(12'h118, 32'h8FFF_FF9F);
    rd_chk(12'h118, 32'h8000_001F, "R2");
    txn(32'h0001_0000, 0, 0, 0, "R4");
    txn(32'h0002_0000, 0, 0, 1, "R4");
    txn(32'h0001_FFFC, 0, 0, 0, "R4");
    txn(32'h0000_FFFC, 0, 0, 1, "R4");
    txn(32'h0001_8000, 0, 1, 1, "R5");

    // R4 undersized code acts as 32 KiB
    wr(12'h120, 32'h0004_0000);
    wr(12'h128, 32'h0000_0007);
    txn(32'h0004_7FFC, 0, 0, 0, "R4");
    txn(32'h0004_8000, 0, 0, 1, "R4");

    // R7 priority
    wr(12'h130, 32'h0);
    wr(12'h138, 32'h3000_003F);
    txn(32'h0001_0000, 0, 0, 1, "R7");
    txn(32'h0004_0000, 0, 0, 1, "R7");
    txn(32'hF000_0000, 0, 0, 1, "R4");
    wr(12'h150, 32'h0001_0000);
    wr(12'h158, 32'h0000_001D);
    txn(32'h0001_0000, 0, 0, 0, "R7");
    txn(32'h0001_8000, 0, 0, 1, "R7");

    // R8 enable bit
    wr(12'h158, 32'h0000_001C);
    rd_chk(12'h158, 32'h0000_001C, "R8");
    rd_chk(12'h150, 32'h0001_0000, "R8");
    txn(32'h0001_0000, 0, 0, 1, "R8");
    wr(12'h158, 32'h0000_001D);
    txn(32'h0001_0000, 0, 0, 0, "R8");

    // R10 lock: one-cycle pulse with a write in the same cycle
    cur_req = "R10";
    @(negedge clk);
    lock_in = 1; cfg_we = 1; cfg_addr = 12'h118; cfg_wdata = 32'h0;
    @(negedge clk);
    lock_in = 0; cfg_we = 0;
    rd_chk(12'h118, 32'h8000_001F, "R10");
    wr(12'h158, 32'h0000_001C);
    rd_chk(12'h158, 32'h0000_001D, "R10");
    wr(12'h004, 32'h0);
    rd_chk(12'h004, 32'h1, "R10");
    txn(32'h0001_0000, 0, 0, 0, "R10");

    // R11 reset clears state and lock
    do_reset();
    cur_req = "R11";
    @(negedge clk);
    chk("R11", "idle outputs after reset", {30'b0, fwd_valid, deny_pulse}, 32'h0);
    rd_chk(12'h118, 32'h0, "R11");
    rd_chk(12'h158, 32'h0, "R11");
    rd_chk(12'h108, 32'hC000_007F, "R3");
    rd_chk(12'h000, 32'h7, "R1");
    wr(12'h118, 32'h0000_0001);
    rd_chk(12'h118, 32'h0000_0001, "R10");

    // R9 mixed traffic against the model
    cur_req = "R9";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) begin
        cfg_we = 1;
        cfg_addr = ($urandom_range(0, 9) == 0) ? 12'h004
                   : {4'h1, 4'($urandom_range(0, N - 1)), 2'($urandom_range(0, 3)), 2'b00};
        cfg_wdata = $urandom;
        if ($urandom_range(0, 1) == 1) cfg_wdata[31:15] = 17'($urandom_range(0, 31)) << 1;
      end else begin
        cfg_we = 0;
        cfg_addr = {4'h1, 4'($urandom_range(0, N - 1)), 2'($urandom_range(0, 3)), 2'b00};
      end
      txn_valid  = $urandom_range(0, 3) != 0;
      txn_addr   = ($urandom_range(0, 3) == 0) ? $urandom : ($urandom & 32'h000F_FFFC);
      txn_write  = $urandom_range(0, 1) == 1;
      txn_secure = $urandom_range(0, 1) == 1;
      if (!cfg_we) begin
        #1;
        chk("R2", $sformatf("read 0x%03h vs model", cfg_addr), cfg_rdata, model_read(cfg_addr));
      end
    end
    @(negedge clk);
    cfg_we = 0; txn_valid = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule